// File: doc/BRIEF.md
# Sound-CPU Interrupt Mask and Watchdog Register

This block is a write-only control register on the bus of a sound processor. It serves four interrupt sources: a periodic timer, DMA completion, a "command available" mailbox signal, and the disk interface interrupt. Each source has one control bit. Writing 1 to that bit arms the source. Writing 0 disarms it and discards any request that is waiting.

Raw source events are caught in per-source pending latches. The highest pending source is encoded as a 3-bit priority level for a CPU with seven interrupt levels. The timer maps to level 1, DMA to level 2, the mailbox to level 4 and the disk interface to level 6.

A separate bit of the same register feeds a watchdog. Software keeps the watchdog quiet by flipping that bit. If the bit stays unchanged for the whole timeout window (1200 ms at the real clock, scaled by parameters), the block emits a one-cycle reset pulse and starts a new window.

Top module: `snd_irq_ctrl`

## Requirements
- R1: After reset, `ipl` is 0, `wdog_rst` is 0 and all four sources are disarmed.
- R2: A source event that arrives while its control bit is 0 is dropped, so `ipl` stays 0 even after the source is armed later.
- R3: While armed, an event sets its pending latch, and `ipl` shows the source's level after the clock edge. Bit 7 is the timer (level 1), bit 8 is DMA (level 2), bit 9 is the mailbox (level 4) and bit 10 is the disk interface (level 6). A write that arms a source takes effect from the next cycle, so an event in the same cycle as that write is dropped.
- R4: A pending latch holds after its event goes away, and writing 1 to an already armed bit does not clear it.
- R5: Writing 0 to a control bit clears that pending latch and masks the source. Later events of that source are dropped.
- R6: `ipl` is the highest pending level among 6, 4, 2 and 1, or 0 when nothing is pending.
- R7: When a 0 is written to a bit in the same cycle as that source's event, the clear wins and the latch ends up 0.
- R8: With no kick, `wdog_rst` pulses high for exactly one cycle, LIMIT cycles after reset release. It pulses again every LIMIT cycles after that.
- R9: A write whose bit 11 differs from the previously written bit 11 restarts the watchdog window. Writes that repeat the same bit 11 value do not restart it.
- R10: LIMIT equals CLK_HZ/1000 × TIMEOUT_MS clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | DATA_W | Write data; bits 10:7 are the arm/ack bits and bit 11 is the watchdog kick |
| src_evt | input | 4 | Raw source events: [0] timer, [1] DMA, [2] mailbox, [3] disk |
| ipl | output | 3 | Encoded interrupt level: 0, 1, 2, 4 or 6 |
| wdog_rst | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The bench checks how events and writes interact. An event on a masked source must not leave a hidden request behind. A buggy design would show it as soon as the source is armed. An event that lands in the same cycle as an arming write or a clearing write would expose a design that used the new enable too early or let the set override the clear. Re-writing 1 to an armed bit must not eat the pending request.

On the watchdog side, the bench measures the exact expiry distance. It checks that the pulse lasts one cycle. It also checks that repeated writes of an unchanged kick bit do not hold off expiry, which would catch a watchdog that reloads on any write instead of on a toggle.

// File: rtl/snd_irq_pkg.sv
package snd_irq_pkg;
    localparam int NSRC     = 4;
    localparam int IRQ_LSB  = 7;
    localparam int KICK_POS = 11;
    localparam int LVL_W    = 3;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t en;
        src_vec_t pend;
    } irq_state_t;

    // source index -> CPU priority level (ascending with index)
    function automatic logic [LVL_W-1:0] level_of(input int idx);
        case (idx)
            0:       return 3'd1;
            1:       return 3'd2;
            2:       return 3'd4;
            default: return 3'd6;
        endcase
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import snd_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  src_vec_t ctl_bits,
    input  src_vec_t src_evt,
    output src_vec_t pend
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.en = ctl_bits;
        end
        for (int i = 0; i < NSRC; i++) begin
            if (wr_en && !ctl_bits[i]) begin
                st_d.pend[i] = 1'b0;
            end else if (st_q.en[i] && src_evt[i]) begin
                st_d.pend[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        AST_SET_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.pend[g]) |-> $past(st_q.en[g] && src_evt[g])); // R2
        AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !ctl_bits[g]) |=> !st_q.pend[g]); // R5
        AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.pend[g] && !wr_en) |=> st_q.pend[g]); // R4
    end
endmodule

// File: rtl/irq_lvl_enc.sv
module irq_lvl_enc
    import snd_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  src_vec_t         pend,
    output logic [LVL_W-1:0] lvl
);
    always_comb begin
        lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i]) begin
                lvl = level_of(i);
            end
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (lvl == '0)); // R6
    AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pend[NSRC-1] |-> (lvl == level_of(NSRC-1))); // R6
endmodule

// File: rtl/wdog_kick.sv
module wdog_kick #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic kick_bit,
    output logic fire
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic             last;
        logic [CNT_W-1:0] cnt;
        logic             fire;
    } wd_t;

    wd_t wd_d, wd_q;
    logic toggled;

    assign toggled = wr_en && (kick_bit != wd_q.last);

    always_comb begin
        wd_d      = wd_q;
        wd_d.fire = 1'b0;
        if (wr_en) begin
            wd_d.last = kick_bit;
        end
        if (toggled) begin
            wd_d.cnt = RELOAD;
        end else if (wd_q.cnt == '0) begin
            wd_d.cnt  = RELOAD;
            wd_d.fire = 1'b1;
        end else begin
            wd_d.cnt = wd_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_q.last <= 1'b0;
            wd_q.cnt  <= RELOAD;
            wd_q.fire <= 1'b0;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign fire = wd_q.fire;

    AST_WD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_q.fire |=> !wd_q.fire); // R8
    AST_WD_FIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wd_q.fire |-> ($past(wd_q.cnt) == '0)); // R8
    AST_WD_TOGGLE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (kick_bit != wd_q.last)) |=> (!wd_q.fire && wd_q.cnt == RELOAD)); // R9
endmodule

// File: rtl/snd_irq_ctrl.sv
module snd_irq_ctrl
    import snd_irq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CLK_HZ     = 50_000_000,
    parameter int TIMEOUT_MS = 1200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NSRC-1:0]   src_evt,
    output logic [LVL_W-1:0]  ipl,
    output logic              wdog_rst
);
    localparam int LIMIT = (CLK_HZ / 1000) * TIMEOUT_MS; // R10

    src_vec_t ctl_bits;
    src_vec_t pend;
    logic     unused_bits;

    assign ctl_bits    = wr_data[IRQ_LSB +: NSRC];
    assign unused_bits = ^{wr_data[DATA_W-1:KICK_POS+1], wr_data[IRQ_LSB-1:0]};

    irq_pend_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .ctl_bits (ctl_bits),
        .src_evt  (src_evt),
        .pend     (pend)
    );

    irq_lvl_enc u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .lvl   (ipl)
    );

    wdog_kick #(.LIMIT(LIMIT)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .kick_bit (wr_data[KICK_POS]),
        .fire     (wdog_rst)
    );
endmodule

// File: tb/snd_irq_ctrl_tb.sv
module snd_irq_ctrl_tb;
    localparam int CLK_HZ     = 100_000;
    localparam int TIMEOUT_MS = 1;
    localparam int EXP_LIMIT  = (CLK_HZ / 1000) * TIMEOUT_MS; // R10

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [3:0]  src_evt = '0;
    logic [2:0]  ipl;
    logic        wdog_rst;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic [2:0] lvl;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk; // 50 MHz

    snd_irq_ctrl #(.DATA_W(16), .CLK_HZ(CLK_HZ), .TIMEOUT_MS(TIMEOUT_MS)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .src_evt  (src_evt),
        .ipl      (ipl),
        .wdog_rst (wdog_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected level after the edge
    task automatic step(input logic we, input logic [15:0] d, input logic [3:0] e,
                        input logic [2:0] lvl, input string tag);
        exp_t it;
        @(negedge clk);
        wr_en = we; wr_data = d; src_evt = e;
        it.lvl = lvl; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compare just after each edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            check(it.tag, int'(ipl), int'(it.lvl));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog timeout of bench");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!wdog_rst && n < 1000);
    endtask

    initial begin
        int n;
        int hits;
        repeat (3) @(negedge clk);
        check("R1 reset ipl", int'(ipl), 0);
        check("R1 reset wdog", int'(wdog_rst), 0);
        @(negedge clk); rst_n = 1'b1;

        step(0, 16'h0000, 4'b0000, 3'd0, "R1 idle after reset");
        step(0, 16'h0000, 4'b1111, 3'd0, "R2 event while disarmed");
        step(1, 16'h0780, 4'b0000, 3'd0, "R2 arm shows no stale request");
        step(0, 16'h0000, 4'b0001, 3'd1, "R3 timer level 1");
        step(0, 16'h0000, 4'b0000, 3'd1, "R4 hold after event");
        step(0, 16'h0000, 4'b0010, 3'd2, "R6 dma over timer");
        step(0, 16'h0000, 4'b0100, 3'd4, "R6 mailbox over dma");
        step(0, 16'h0000, 4'b1000, 3'd6, "R3 disk level 6");
        step(1, 16'h0780, 4'b0000, 3'd6, "R4 rewrite 1 keeps pending");
        step(1, 16'h0380, 4'b0000, 3'd4, "R5 clear disk");
        step(1, 16'h0180, 4'b0000, 3'd2, "R5 clear mailbox");
        step(0, 16'h0000, 4'b1000, 3'd2, "R5 masked disk dropped");
        step(1, 16'h0080, 4'b0010, 3'd1, "R7 clear beats event");
        step(1, 16'h0000, 4'b0000, 3'd0, "R5 clear all");
        step(1, 16'h0100, 4'b0010, 3'd0, "R3 arm same cycle drops event");
        step(0, 16'h0000, 4'b0010, 3'd2, "R3 dma after arm");
        step(1, 16'h0000, 4'b0000, 3'd0, "R5 final clear");
        @(negedge clk); wr_en = 1'b0; src_evt = '0;
        repeat (3) @(negedge clk);

        // watchdog section
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wait_pulse(n);
        check("R8 R10 first expiry distance", n, EXP_LIMIT);
        @(posedge clk); #1;
        check("R8 pulse one cycle", int'(wdog_rst), 0);
        wait_pulse(n);
        check("R8 repeat period", n + 1, EXP_LIMIT);

        // toggling keeps it quiet
        hits = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); wr_en = 1'b1; wr_data = (k % 2 == 0) ? 16'h0800 : 16'h0000;
            @(negedge clk); wr_en = 1'b0;
            for (int j = 0; j < 60; j++) begin
                @(posedge clk); #1;
                if (wdog_rst) hits++;
            end
        end
        check("R9 toggles prevent expiry", hits, 0);

        // last toggle, then same-value writes must not reload
        @(negedge clk); wr_en = 1'b1; wr_data = 16'h0800;
        n = 0;
        do begin
            @(negedge clk);
            wr_en = (n % 30 == 29);
            wr_data = 16'h0800;
            @(posedge clk); #1; n++;
        end while (!wdog_rst && n < 1000);
        wr_en = 1'b0;
        check("R9 same-value writes ignored", n, EXP_LIMIT);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule